// File: doc/BRIEF.md
# RTC Interrupt Flags and Periodic Rate

This block is the interrupt front end of a PC-style real-time clock. It divides the system clock down to a 32.768 kHz reference, and from that reference it makes a periodic event at a rate set by a 4-bit code. It latches three event sources into raw flags: the periodic event, an alarm-match strobe and an update-ended strobe. The last two come from neighbouring blocks. A control register holds one enable per source. A summary bit and an active-low interrupt line follow only those flags whose enable is set.

Software reaches the block through a byte-wide register port with a 2-bit select. The port is plain: a read or write strobe is taken in the cycle it is high, and there is no handshake or back-pressure. Read data appears on the cycle after the read strobe. Reading the flag register is the acknowledge: it clears every flag at once. Drivers also use this read to flush stale status after they change enables.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A rate code of 0 produces no periodic events, so the periodic flag never sets.
- R2: A rate code n from 1 to 15 produces one periodic event every 2^(n-1) reference ticks, which is 2^(16-n) Hz from 32.768 kHz (code 15 is 2 Hz). One reference tick lasts REF_DIV clocks.
- R3: After reset the rate code is 6 (1024 Hz), all enables and flags are 0, and irq_n is 1.
- R4: Each event sets its raw flag whether or not its enable is set. In the flag register, bit 6 is periodic, bit 5 is alarm, bit 4 is update-ended, and bits 3:0 read 0.
- R5: The control register holds the periodic, alarm and update enables at bits 6, 5 and 4, the same positions as the flags. Its other bits read 0, and writes to them are ignored.
- R6: Flag bit 7 (summary) is 1 exactly when some flag is set together with its enable. Setting an enable while its flag is already pending raises the summary bit, and clearing the enable drops it.
- R7: irq_n is 0 whenever the summary bit is 1 and is 1 otherwise, and it changes in the cycle after the cause.
- R8: A flag-register read returns the value held before the read. It clears all flags and the summary bit, and irq_n is 1 on the following cycle unless a new enabled event arrived.
- R9: An event that arrives in the same cycle as a flag-register read is kept, and the next read shows it.
- R10: reg_sel encodes 0 = rate, 1 = control, 2 = flags, 3 = unused (reads 0). The rate register keeps the code in bits 3:0, its upper bits read 0, and read data is valid the cycle after reg_rd.
- R11: A one-cycle pulse on alarm_hit or update_done sets its flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| alarm_hit | input | 1 | Alarm-match event pulse |
| update_done | input | 1 | Update-ended event pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event strobe that lands in the same cycle as the clearing read. Here the read must return the old value and the new flag must survive. The stimulus table places an update_done pulse on the very cycle of a flag read while that update is enabled. It then checks that irq_n stays low and that a second read still shows the flag. The long periodic intervals are also hard to observe from the ports alone. The bench times the gap between two falling edges of irq_n with only the periodic enable set, and it acknowledges in between. This covers codes 3, 6 and 15. A separate idle window confirms that code 0 is silent.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_SUM  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_ALM  = 5;
  localparam int BIT_UPD  = 4;

  typedef enum logic [1:0] {
    SEL_RATE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_FLAGS = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // one bit per event source: [2] periodic, [1] alarm, [0] update-ended
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;
endpackage

// File: rtl/rtc_ref_prescaler.sv
module rtc_ref_prescaler #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign ref_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ref_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [RATE_W-1:0] rate,
  output logic              pulse
);
  localparam int CHAIN_W = (2 ** RATE_W) - 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] mask;

  // code n compares the low n-1 stages, giving a period of 2^(n-1) ticks
  always_comb begin
    for (int i = 0; i < CHAIN_W; i++) begin
      mask[i] = ((i + 1) < int'(rate));
    end
  end

  assign pulse = ref_tick && (rate != '0) && ((chain_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)        chain_q <= '0;
    else if (ref_tick) chain_q <= chain_q + 1'b1;
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t events,
  input  logic clear,
  input  evt_t enables,
  output evt_t flags,
  output logic summary
);
  evt_t flags_q;

  // a clearing read wipes old flags, but events of the same cycle land on top
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clear ? evt_t'('0) : flags_q) | events;
  end

  assign flags   = flags_q;
  assign summary = |(flags_q & enables);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W     = 4,
  parameter int REF_DIV    = 1,
  parameter int RESET_RATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              alarm_hit,
  input  logic              update_done,
  output logic              irq_n
);
  localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RESET_RATE);

  logic              ref_tick;
  logic              per_pulse;
  logic [RATE_W-1:0] rate_q;
  evt_t              en_q;
  evt_t              flag_vec;
  evt_t              evt_in;
  logic              summary;
  logic              rd_flags;
  logic [DATA_W-1:0] rd_next;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(reg_sel);
  assign rd_flags = reg_rd && (sel == SEL_FLAGS);
  assign evt_in   = '{per: per_pulse, alm: alarm_hit, upd: update_done};

  rtc_ref_prescaler #(.DIV(REF_DIV)) presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick)
  );

  rtc_periodic_gen #(.RATE_W(RATE_W)) pgen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .rate     (rate_q),
    .pulse    (per_pulse)
  );

  rtc_flag_unit flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .events  (evt_in),
    .clear   (rd_flags),
    .enables (en_q),
    .flags   (flag_vec),
    .summary (summary)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_INIT;
      en_q   <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_RATE: rate_q <= reg_wdata[RATE_W-1:0];
        SEL_CTRL: en_q   <= '{per: reg_wdata[BIT_PER],
                              alm: reg_wdata[BIT_ALM],
                              upd: reg_wdata[BIT_UPD]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_RATE: rd_next[RATE_W-1:0] = rate_q;
      SEL_CTRL: begin
        rd_next[BIT_PER] = en_q.per;
        rd_next[BIT_ALM] = en_q.alm;
        rd_next[BIT_UPD] = en_q.upd;
      end
      SEL_FLAGS: begin
        rd_next[BIT_SUM] = summary;
        rd_next[BIT_PER] = flag_vec.per;
        rd_next[BIT_ALM] = flag_vec.alm;
        rd_next[BIT_UPD] = flag_vec.upd;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  assign irq_n = ~summary;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              alarm_hit,
  input logic              update_done,
  input logic              per_pulse,
  input logic [RATE_W-1:0] rate_q,
  input logic [2:0]        en_vec,
  input logic [2:0]        flag_vec,
  input logic              irq_n
);
  logic rd_flags;
  logic wr_ctrl;
  assign rd_flags = reg_rd && (reg_sel == 2'd2);
  assign wr_ctrl  = reg_wr && (reg_sel == 2'd1);

  assert_rate_zero_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |-> !per_pulse);

  assert_raw_alarm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flag_vec[1]);

  assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(alarm_hit || update_done || per_pulse || wr_ctrl));

  assert_enabled_alarm_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && en_vec[1] && !wr_ctrl) |=> !irq_n);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !alarm_hit && !update_done && !per_pulse) |=> (irq_n && (flag_vec == 3'b000)));

  assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && update_done) |=> flag_vec[0]);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.RATE_W(RATE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .alarm_hit   (alarm_hit),
  .update_done (update_done),
  .per_pulse   (per_pulse),
  .rate_q      (rate_q),
  .en_vec      (en_q),
  .flag_vec    (flag_vec),
  .irq_n       (irq_n)
);

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
  localparam int REF_DIV = 2;
  localparam int NVEC    = 20;

  // [31] wr [30] rd [29:28] sel | [27:20] wdata | [17] alarm [16] update |
  // [15:8] expected read data | [4] expected irq_n
  localparam logic [31:0] VEC [NVEC] = '{
    32'h6000_0010, // R8 flush read, all clear
    32'h0002_0010, // R11 alarm with enable off: no irq
    32'h6000_2010, // R4 raw alarm flag at bit 5, summary 0
    32'h6000_0010, // R8 cleared by previous read
    32'h9200_0010, // R5 enable alarm
    32'h0002_0000, // R7 enabled alarm drives irq_n low
    32'h5000_2000, // R5 control reads back alarm enable
    32'h6000_A010, // R8 summary plus alarm, irq released
    32'h0001_0010, // R4 update flag raw, no enable
    32'h9300_0000, // R6 enabling a pending flag raises summary
    32'h6001_9000, // R9 read with update in same cycle
    32'h6000_9010, // R9 the new update flag survived
    32'h9003_0010, // R6 enables dropped as both events land
    32'h6000_3010, // R4 both raw flags, no summary
    32'h9FF0_0010, // R5 write all ones to control
    32'h5000_7010, // R5 only bits 6..4 stored
    32'h9000_0010, // control back to zero
    32'h7000_0010, // R10 select 3 reads zero
    32'h8F00_0010, // R10 rate write, code 0 in low nibble
    32'h4000_0010  // R10 rate reads 00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_hit = 1'b0;
  logic       update_done = 1'b0;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl #(.RATE_W(4), .REF_DIV(REF_DIV), .RESET_RATE(6)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .alarm_hit   (alarm_hit),
    .update_done (update_done),
    .irq_n       (irq_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 180000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 180000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle, returns at the following negedge
  task automatic op(input logic wr, input logic rd, input logic [1:0] sel,
                    input logic [7:0] wd, input logic alm, input logic upd);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    alarm_hit = alm; update_done = upd;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; alarm_hit = 1'b0; update_done = 1'b0;
  endtask

  task automatic measure(input int code);
    int t1;
    int t2;
    op(1'b1, 1'b0, 2'd0, 8'(code), 1'b0, 1'b0);
    op(1'b1, 1'b0, 2'd1, 8'h40, 1'b0, 1'b0);
    op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    while (irq_n !== 1'b1) @(negedge clk);
    while (irq_n !== 1'b0) @(negedge clk);
    t1 = cyc;
    op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    check(int'(reg_rdata), 'hC0, "R2 periodic flag with summary");
    while (irq_n !== 1'b0) @(negedge clk);
    t2 = cyc;
    check(t2 - t1, (1 << (code - 1)) * REF_DIV, "R2 periodic interval");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    check(int'(irq_n), 1, "R3 irq_n after reset");
    op(1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    check(int'(reg_rdata), 'h06, "R3 reset rate code");
    op(1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0);
    check(int'(reg_rdata), 'h00, "R3 reset enables");
    op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    check(int'(reg_rdata), 'h00, "R3 reset flags");
    op(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      op(v[31], v[30], v[29:28], v[27:20], v[17], v[16]);
      if (v[30]) check(int'(reg_rdata), int'(v[15:8]), $sformatf("vector %0d read data", i));
      check(int'(irq_n), int'(v[4]), $sformatf("vector %0d irq_n", i));
    end

    measure(3);
    measure(6);
    measure(15);

    // R1 code 0 stays silent with periodic enable on
    op(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    begin
      int lows;
      lows = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (irq_n !== 1'b1) lows = lows + 1;
      end
      check(lows, 0, "R1 irq_n stays high at code 0");
    end
    op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    check(int'(reg_rdata), 'h00, "R1 no periodic flag at code 0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule